// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a reference clock into a one-cycle enable pulse that fires, on average, once per microsecond. The reference may run at a frequency that is not a whole number of MHz. The rate is set by a fractional ratio. An accumulator adds the numerator on every clock. When the running sum reaches the denominator, the accumulator subtracts the denominator and emits a tick. A 19.2 MHz reference can therefore produce exactly 5 ticks every 96 clocks.

The tick enables the other timers of the subsystem. It also advances a free-running microsecond counter that software reads over a small 32-bit register bus. A freeze control lets a debug halt stop both the phase accumulator and the counter. When the halt ends, timing resumes from the same phase.

The bus has three registers:

- Ratio register at byte address 0x14: divisor minus one in bits [7:0] and dividend minus one in bits [15:8].
- Counter register at 0x10: read only.
- Freeze register at 0x4C: enable in bit 0.

Top module: `us_tick_gen`

## Requirements
- R1: After reset, the ratio register reads 0x0000000B, the counter reads 0, the freeze register reads 0, and tick_o is low.
- R2: A write to address 0x14 stores bits [7:0] as divisor minus one and bits [15:8] as dividend minus one. A read of 0x14 returns those 16 bits with all upper bits zero.
- R3: After a ratio write, with dividend ≤ divisor, the number of ticks in the next N clocks equals floor(N·(dividend+1)/(divisor+1)). Each tick lasts one clock.
- R4: The value 0x000B gives its first tick 12 clocks after a write or after reset. The value 0x000C gives it after 13 clocks and 0x0019 after 26 clocks. The value 0x045F gives 50 ticks in 960 clocks.
- R5: The counter read at 0x10 increases by exactly one in the same cycle that tick_o is high, and it is unchanged in every other cycle.
- R6: The counter wraps from all ones to zero and keeps counting.
- R7: While freeze bit 0 is set and dbg_halt_i is high, no ticks occur and both the counter and the accumulator phase hold. After release, the next tick comes after the remaining part of the period.
- R8: Counting continues when only one of the two conditions holds: the freeze bit is set with dbg_halt_i low, or dbg_halt_i is high with the freeze bit clear.
- R9: A ratio write clears the accumulator, so the first tick after a write mid-period arrives one full period later. No tick is emitted in the cycle after the write.
- R10: Writes to the counter address or to unmapped addresses change neither the counter nor the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte address (used for both write and read) |
| wdata_i | input | 32 | Write data |
| dbg_halt_i | input | 1 | Debug halt request |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_o | output | 1 | One-cycle microsecond tick enable |

## Verification
The bench builds the block with an 8-bit ratio field and an 8-bit counter. The narrow counter brings the wrap from all ones to zero within a few hundred clocks. It also lets the bench confirm that every tick is counted once. The full 8-bit ratio fields keep the 0x045F programming reachable. The bench sweeps every ratio with divisor field 0 to 31 and dividend no larger than divisor. For each one it compares the tick count against the floor formula over about two periods.

// File: rtl/us_tick_pkg.sv
package us_tick_pkg;
  localparam int unsigned ADDR_COUNT  = 32'h10;
  localparam int unsigned ADDR_RATIO  = 32'h14;
  localparam int unsigned ADDR_FREEZE = 32'h4C;
  // reset ratio 1/12: fields hold value minus one
  localparam int unsigned RST_DIVIDEND = 0;
  localparam int unsigned RST_DIVISOR  = 11;
endpackage

// File: rtl/us_tick_regs.sv
module us_tick_regs
  import us_tick_pkg::*;
#(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [FRAC_W-1:0] dvd_o,
  output logic [FRAC_W-1:0] dvs_o,
  output logic              frz_en_o,
  output logic              ratio_wr_o,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(ADDR_COUNT);
  localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(ADDR_RATIO);
  localparam logic [ADDR_W-1:0] A_FRZ   = ADDR_W'(ADDR_FREEZE);

  logic [FRAC_W-1:0] dvd_q, dvs_q;
  logic              frz_q;
  logic              frz_wr;
  logic              unused_wdata;

  assign ratio_wr_o   = wr_en_i && (addr_i == A_RATIO);
  assign frz_wr       = wr_en_i && (addr_i == A_FRZ);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= FRAC_W'(RST_DIVIDEND);
      dvs_q <= FRAC_W'(RST_DIVISOR);
      frz_q <= 1'b0;
    end else begin
      if (ratio_wr_o) begin
        dvs_q <= wdata_i[FRAC_W-1:0];
        dvd_q <= wdata_i[2*FRAC_W-1:FRAC_W];
      end
      if (frz_wr) frz_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_RATIO) begin
      rdata_o[FRAC_W-1:0]        = dvs_q;
      rdata_o[2*FRAC_W-1:FRAC_W] = dvd_q;
    end else if (addr_i == A_CNT) begin
      rdata_o[CNT_W-1:0] = cnt_i;
    end else if (addr_i == A_FRZ) begin
      rdata_o[0] = frz_q;
    end
  end

  assign dvd_o    = dvd_q;
  assign dvs_o    = dvs_q;
  assign frz_en_o = frz_q;
endmodule

// File: rtl/us_tick_frac.sv
module us_tick_frac #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [FRAC_W-1:0] dvd_i,
  input  logic [FRAC_W-1:0] dvs_i,
  output logic              wrap_o,
  output logic [FRAC_W:0]   acc_o
);
  localparam int unsigned ACC_W = FRAC_W + 1;
  localparam int unsigned SUM_W = FRAC_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum, modulus, nxt;
  logic             reach;

  assign sum     = SUM_W'(acc_q) + SUM_W'(dvd_i) + SUM_W'(1);
  assign modulus = SUM_W'(dvs_i) + SUM_W'(1);
  assign reach   = sum >= modulus;
  assign nxt     = reach ? sum - modulus : sum;
  assign wrap_o  = run_i && !clr_i && reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (run_i) acc_q <= ACC_W'(nxt);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/us_tick_count.sv
module us_tick_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             tick_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tick_q <= inc_i;
      if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              dbg_halt_i,
  output logic [31:0]       rdata_o,
  output logic              tick_o
);
  logic [FRAC_W-1:0] dvd, dvs;
  logic              frz_en, ratio_wr, run, wrap;
  logic [FRAC_W:0]   acc;
  logic [CNT_W-1:0]  cnt;

  assign run = !(frz_en && dbg_halt_i);

  us_tick_regs #(.FRAC_W(FRAC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .dvd_o      (dvd),
    .dvs_o      (dvs),
    .frz_en_o   (frz_en),
    .ratio_wr_o (ratio_wr),
    .rdata_o    (rdata_o)
  );

  us_tick_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (ratio_wr),
    .dvd_i  (dvd),
    .dvs_i  (dvs),
    .wrap_o (wrap),
    .acc_o  (acc)
  );

  us_tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wrap),
    .tick_o (tick_o),
    .cnt_o  (cnt)
  );
endmodule

// File: rtl/us_tick_gen_chk.sv
module us_tick_gen_chk #(
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_halt_i,
  input logic              tick_o,
  input logic              frz_en,
  input logic              ratio_wr,
  input logic [FRAC_W-1:0] dvd,
  input logic [FRAC_W-1:0] dvs,
  input logic [FRAC_W:0]   acc,
  input logic [CNT_W-1:0]  cnt
);
  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  // R5
  count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(cnt));

  // R7
  frozen_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en && dbg_halt_i) |=> !tick_o);

  // R7
  frozen_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en && dbg_halt_i && !ratio_wr) |=> $stable(acc));

  // R9
  ratio_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_wr |=> (acc == '0) && !tick_o);

  // R3
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvd <= dvs) |-> (acc <= {1'b0, dvs}));
endmodule

bind us_tick_gen us_tick_gen_chk #(.FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbg_halt_i (dbg_halt_i),
  .tick_o     (tick_o),
  .frz_en     (frz_en),
  .ratio_wr   (ratio_wr),
  .dvd        (dvd),
  .dvs        (dvs),
  .acc        (acc),
  .cnt        (cnt)
);

// File: tb/tb_us_tick_gen.sv
`timescale 1ns/1ps
module tb_us_tick_gen;
  localparam int unsigned FRAC_W = 8;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              halt = 1'b0;
  logic [31:0]       rdata;
  logic              tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  us_tick_gen #(.FRAC_W(FRAC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .dbg_halt_i (halt),
    .rdata_o    (rdata),
    .tick_o     (tick)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(input int n, output int t);
    t = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick) t++;
    end
  endtask

  task automatic first_tick(input int lim, output int idx);
    idx = -1;
    for (int k = 1; k <= lim && idx < 0; k++) begin
      @(negedge clk);
      if (tick) idx = k;
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] d, c0, c1;
    int t, idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h14, d); check("R1 ratio", d, 32'h0000000B);
    rd(8'h10, d); check("R1 counter", d, 0);
    rd(8'h4C, d); check("R1 freeze", d, 0);
    check("R1 tick", tick, 0);
    // R4 default 1/12 from reset
    first_tick(100, idx); check("R4 reset first tick", idx, 12);

    // R2 field layout and readback
    wr(8'h14, 32'hFFFF_045F);
    rd(8'h14, d); check("R2 readback", d, 32'h0000045F);
    rd(8'h10, c0);
    run(960, t);
    rd(8'h10, c1);
    check("R4 19.2 ratio ticks", t, 50);
    check("R5 counter delta", (c1 - c0) & 32'hFF, t);

    wr(8'h14, 32'h000C); first_tick(100, idx); check("R4 13 period", idx, 13);
    wr(8'h14, 32'h0019); first_tick(100, idx); check("R4 26 period", idx, 26);

    // R9 mid-period rewrite restarts phase
    wr(8'h14, 32'h000B);
    run(5, t);
    wr(8'h14, 32'h000B);
    check("R9 no tick after write", tick, 0);
    first_tick(100, idx); check("R9 restart period", idx, 12);

    // R3 sweep of ratios
    for (int s = 0; s < 32; s++) begin
      for (int dv = 0; dv <= s; dv++) begin
        int n;
        n = 2 * (s + 1) + 3;
        wr(8'h14, (dv << 8) | s);
        rd(8'h10, c0);
        run(n, t);
        rd(8'h10, c1);
        check("R3 tick count", t, (n * (dv + 1)) / (s + 1));
        check("R5 sweep counter", (c1 - c0) & 32'hFF, t);
      end
    end

    // R6 wrap
    wr(8'h14, 32'h0000);
    rd(8'h10, d);
    for (int k = 0; k < 300 && d != 32'hFF; k++) begin
      run(1, t);
      rd(8'h10, d);
    end
    check("R6 reached all ones", d, 32'hFF);
    run(1, t);
    rd(8'h10, d); check("R6 wrap to zero", d, 0);
    rd(8'h10, c0); run(300, t); rd(8'h10, c1);
    check("R6 continuous", c1, (c0 + 300) & 32'hFF);

    // R8 halt alone, then freeze bit alone
    halt = 1'b1;
    run(50, t); check("R8 halt only", t, 50);
    halt = 1'b0;
    wr(8'h4C, 32'h1);
    rd(8'h4C, d); check("R8 freeze readback", d, 1);
    run(50, t); check("R8 freeze bit only", t, 50);

    // R7 freeze holds phase and counter
    wr(8'h14, 32'h000B);
    run(5, t);
    halt = 1'b1;
    rd(8'h10, c0);
    run(20, t); check("R7 no ticks frozen", t, 0);
    rd(8'h10, c1); check("R7 counter held", c1, c0);
    halt = 1'b0;
    first_tick(100, idx); check("R7 resumes phase", idx, 7);

    // R10 ignored writes
    halt = 1'b1;
    rd(8'h10, c0);
    wr(8'h10, 32'hAA);
    rd(8'h10, c1); check("R10 counter not writable", c1, c0);
    wr(8'h20, 32'h1234);
    rd(8'h14, d); check("R10 unmapped write", d, 32'h0000000B);
    rd(8'h10, c1); check("R10 counter after unmapped", c1, c0);
    halt = 1'b0;

    done = 1;
    report();
  end
endmodule